// File: doc/BRIEF.md
# Soft-Decision Check Node with Approximate Box-Plus

This block is the check-node processor of an iterative soft-decision parity-check decoder. In one beat it accepts the signed fixed-point log-likelihood ratios arriving from the variable nodes on every edge of one check. For each edge it returns an extrinsic message that combines all the other edges' values and leaves out that edge's own value. The result for each edge goes back to the variable node on that edge, and the whole update is repeated on every decoder iteration.

Messages are combined pairwise with the box-plus operator, boxplus(a,b) = max*(a,b) - max*(0,a+b). Here max* is approximated in hardware: the logarithmic correction term is replaced by a constant offset of 3/8 that applies only inside a window of the two operands, so no logarithm or exponential is evaluated. A forward prefix chain and a backward suffix chain share their partial results, so all edge outputs come out of one pass. A configurable register pipeline follows. Output valid tracks input valid with a fixed latency, and the output vector holds its value between results.

Top module: `llr_check_node`

## Requirements
- R1: Each message is a DATA_W-bit (default 8) two's-complement value with FRAC_W (default 3) fractional bits. Edge i occupies bits [i*DATA_W +: DATA_W] of both the input and the output vector. The default degree is 4 edges.
- R2: The approximate max*(a,b) is max(a,b) + 3 codes (3/8) when |a-b| is at most 16 codes (2.0). Otherwise it is max(a,b), so a difference of 16 gets the offset and a difference of 17 does not.
- R3: boxplus(a,b) first saturates a+b to the DATA_W range, then forms max*(a,b) - max*(0, saturated sum), and saturates that result to the DATA_W range (-128..127 by default).
- R4: boxplus with a zero operand gives zero, so when any input edge is 0 every other edge's output is 0.
- R5: The magnitude of one box-plus is at most the smaller operand magnitude plus 3 codes. Each edge output therefore has a magnitude of at most the smallest other-edge magnitude plus 3*(degree-2) codes.
- R6: The prefix F0 = x0 and Fk = boxplus(F(k-1), xk) runs left to right. The suffix B(D-1) = x(D-1) and Bk = boxplus(xk, B(k+1)) runs right to left. Output 0 is B1, output D-1 is F(D-2), and output i in between is boxplus(F(i-1), B(i+1)).
- R7: Reset clears out_valid and out_llr to 0. out_valid rises exactly LATENCY rising edges after the edge that samples in_valid, counting that edge as the first, and is never high earlier.
- R8: While out_valid is low, out_llr keeps its last value. Input data presented with in_valid low has no effect on any output.
- R9: For the inputs (-57, -12, -3, 46) in codes on edges 0..3, output 0 is 3 (0.375). This is the quantised form of a check whose other inputs are about -1.53, -0.33 and 5.76.
- R10: At the extremes of the range (all inputs 127, all inputs -128, or alternating 127 and -128), every output is the saturated value defined by R3 and R6, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_llr on this edge |
| in_llr | input | DEGREE*DATA_W | Packed incoming messages, edge i at [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Qualifies a newly produced out_llr |
| out_llr | output | DEGREE*DATA_W | Packed extrinsic messages, same edge layout |

## Verification
The bench goes after the edge of the correction window: an operand difference of exactly 16 codes must get the 3/8 offset and 17 must not. A design with an off-by-one or strict comparison would be off by 3 codes on those outputs. Saturated vectors of all 127, all -128 and alternating signs expose a missing clamp on the intermediate sum or on the final difference, which would show up as a sign flip from wrap-around. A zero on one edge must force zero on every other edge, and any mix-up in the prefix and suffix indexing would let an edge's own value leak into its output or reverse the fold order. Bubbles carrying garbage data between valid beats catch a pipeline that loads or shifts data without its valid. A latency off by one stage shows up as out_valid on the wrong cycle.

// File: rtl/llr_cn_pkg.sv
package llr_cn_pkg;

   // Correction offset (3/8) expressed in codes of the chosen fraction width.
   function automatic int unsigned cn_offset_codes(input int unsigned frac_w);
      return 3 << (frac_w - 3);
   endfunction

   // Half-width of the correction window (2.0) in codes.
   function automatic int unsigned cn_window_codes(input int unsigned frac_w);
      return 2 << frac_w;
   endfunction

endpackage

// File: rtl/llr_cn_maxstar.sv
module llr_cn_maxstar
   import llr_cn_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned FRAC_W = 3
) (
   input  logic signed [DATA_W-1:0] op_a,
   input  logic signed [DATA_W-1:0] op_b,
   output logic signed [DATA_W+1:0] res
);
   localparam logic [DATA_W:0]   WINDOW = (DATA_W+1)'(cn_window_codes(FRAC_W));
   localparam logic [DATA_W+1:0] OFFSET = (DATA_W+2)'(cn_offset_codes(FRAC_W));

   generate
      if (FRAC_W < 3) begin : g_bad_frac
         $error("llr_cn_maxstar: FRAC_W must be at least 3");
      end
      if (DATA_W < FRAC_W + 3) begin : g_bad_width
         $error("llr_cn_maxstar: DATA_W too small for the correction window");
      end
   endgenerate

   logic signed [DATA_W:0]   diff;
   logic        [DATA_W:0]   abs_diff;
   logic signed [DATA_W-1:0] larger;
   logic                     in_window;

   always_comb begin
      diff      = {op_a[DATA_W-1], op_a} - {op_b[DATA_W-1], op_b};
      abs_diff  = diff[DATA_W] ? (DATA_W+1)'(-diff) : diff;
      larger    = (op_a >= op_b) ? op_a : op_b;
      in_window = (abs_diff <= WINDOW);
      res       = {{2{larger[DATA_W-1]}}, larger} + (in_window ? OFFSET : '0);
   end

endmodule

// File: rtl/llr_cn_boxplus.sv
module llr_cn_boxplus
   import llr_cn_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned FRAC_W = 3
) (
   input  logic signed [DATA_W-1:0] op_a,
   input  logic signed [DATA_W-1:0] op_b,
   output logic signed [DATA_W-1:0] res
);
   localparam logic signed [DATA_W+2:0] HI_W = (DATA_W+3)'((2**(DATA_W-1)) - 1);
   localparam logic signed [DATA_W+2:0] LO_W = -HI_W - 1;
   localparam logic signed [DATA_W-1:0] HI   = HI_W[DATA_W-1:0];
   localparam logic signed [DATA_W-1:0] LO   = LO_W[DATA_W-1:0];
   localparam logic [DATA_W:0]          OFS  = (DATA_W+1)'(cn_offset_codes(FRAC_W));

   logic signed [DATA_W:0]   sum_wide;
   logic signed [DATA_W-1:0] sum_sat;
   logic signed [DATA_W+1:0] ms_pair;
   logic signed [DATA_W+1:0] ms_zero;
   logic signed [DATA_W+2:0] delta;
   logic signed [DATA_W-1:0] zero_op;

   assign zero_op = '0;

   always_comb begin
      sum_wide = {op_a[DATA_W-1], op_a} + {op_b[DATA_W-1], op_b};
      if (sum_wide[DATA_W] != sum_wide[DATA_W-1])
         sum_sat = sum_wide[DATA_W] ? LO : HI;
      else
         sum_sat = sum_wide[DATA_W-1:0];
   end

   llr_cn_maxstar #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_ms_pair (
      .op_a (op_a),
      .op_b (op_b),
      .res  (ms_pair)
   );

   llr_cn_maxstar #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_ms_zero (
      .op_a (zero_op),
      .op_b (sum_sat),
      .res  (ms_zero)
   );

   always_comb begin
      delta = {ms_pair[DATA_W+1], ms_pair} - {ms_zero[DATA_W+1], ms_zero};
      if (delta > HI_W)
         res = HI;
      else if (delta < LO_W)
         res = LO;
      else
         res = delta[DATA_W-1:0];
   end

   // R4 and R5 checks on each pairwise combine.
   logic [DATA_W:0] mag_a, mag_b, mag_r, mag_min;
   always_comb begin
      mag_a   = op_a[DATA_W-1] ? (DATA_W+1)'(-{op_a[DATA_W-1], op_a}) : {1'b0, op_a};
      mag_b   = op_b[DATA_W-1] ? (DATA_W+1)'(-{op_b[DATA_W-1], op_b}) : {1'b0, op_b};
      mag_r   = res[DATA_W-1]  ? (DATA_W+1)'(-{res[DATA_W-1], res})   : {1'b0, res};
      mag_min = (mag_a < mag_b) ? mag_a : mag_b;
      if (!$isunknown({op_a, op_b, res})) begin
         a_r4_zero_operand: assert ((op_a != '0 && op_b != '0) || res == '0)
            else $error("R4: zero operand did not give zero");
         a_r5_magnitude_bound: assert ({1'b0, mag_r} <= {1'b0, mag_min} + {1'b0, OFS})
            else $error("R5: box-plus magnitude exceeds bound");
      end
   end

endmodule

// File: rtl/llr_cn_extrinsic.sv
module llr_cn_extrinsic #(
   parameter int unsigned DEGREE = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned FRAC_W = 3
) (
   input  logic [DEGREE*DATA_W-1:0] msg_in,
   output logic [DEGREE*DATA_W-1:0] msg_out
);
   localparam int unsigned LAST = DEGREE - 1;

   generate
      if (DEGREE < 2) begin : g_bad_degree
         $error("llr_cn_extrinsic: DEGREE must be at least 2");
      end
   endgenerate

   logic signed [DATA_W-1:0] x   [DEGREE];
   logic signed [DATA_W-1:0] fwd [DEGREE-1];
   logic signed [DATA_W-1:0] bwd [1:DEGREE-1];

   generate
      for (genvar e = 0; e < DEGREE; e++) begin : g_unpack
         assign x[e] = msg_in[e*DATA_W +: DATA_W];
      end

      // Forward prefix: left-to-right fold.
      assign fwd[0] = x[0];
      for (genvar k = 1; k <= DEGREE-2; k++) begin : g_fwd
         llr_cn_boxplus #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_bp (
            .op_a (fwd[k-1]),
            .op_b (x[k]),
            .res  (fwd[k])
         );
      end

      // Backward suffix: right-to-left fold.
      assign bwd[LAST] = x[LAST];
      for (genvar k = 1; k <= DEGREE-2; k++) begin : g_bwd
         llr_cn_boxplus #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_bp (
            .op_a (x[k]),
            .op_b (bwd[k+1]),
            .res  (bwd[k])
         );
      end

      // Merge: each edge combines the prefix to its left with the suffix to its right.
      for (genvar e = 0; e < DEGREE; e++) begin : g_edge
         if (e == 0) begin : g_first
            assign msg_out[e*DATA_W +: DATA_W] = bwd[1];
         end else if (e == LAST) begin : g_last
            assign msg_out[e*DATA_W +: DATA_W] = fwd[LAST-1];
         end else begin : g_mid
            logic signed [DATA_W-1:0] merged;
            llr_cn_boxplus #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_bp (
               .op_a (fwd[e-1]),
               .op_b (bwd[e+1]),
               .res  (merged)
            );
            assign msg_out[e*DATA_W +: DATA_W] = merged;
         end
      end
   endgenerate

endmodule

// File: rtl/llr_cn_pipe.sv
module llr_cn_pipe #(
   parameter int unsigned PAY_W   = 32,
   parameter int unsigned LATENCY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_in,
   input  logic [PAY_W-1:0] pay_in,
   output logic             vld_out,
   output logic [PAY_W-1:0] pay_out
);
   generate
      if (LATENCY < 1) begin : g_bad_lat
         $error("llr_cn_pipe: LATENCY must be at least 1");
      end
   endgenerate

   logic             vld_q [LATENCY+1];
   logic [PAY_W-1:0] pay_q [LATENCY+1];

   assign vld_q[0] = vld_in;
   assign pay_q[0] = pay_in;

   generate
      for (genvar s = 1; s <= LATENCY; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[s] <= 1'b0;
               pay_q[s] <= '0;
            end else begin
               vld_q[s] <= vld_q[s-1];
               if (vld_q[s-1])
                  pay_q[s] <= pay_q[s-1];
            end
         end
      end
   endgenerate

   assign vld_out = vld_q[LATENCY];
   assign pay_out = pay_q[LATENCY];

endmodule

// File: rtl/llr_check_node.sv
module llr_check_node #(
   parameter int unsigned DEGREE  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned FRAC_W  = 3,
   parameter int unsigned LATENCY = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [DEGREE*DATA_W-1:0] in_llr,
   output logic                     out_valid,
   output logic [DEGREE*DATA_W-1:0] out_llr
);
   localparam int unsigned VEC_W = DEGREE * DATA_W;
   localparam int unsigned CNT_W = $clog2(LATENCY + 1);

   logic [VEC_W-1:0] extr;

   llr_cn_extrinsic #(.DEGREE(DEGREE), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_extr (
      .msg_in  (in_llr),
      .msg_out (extr)
   );

   llr_cn_pipe #(.PAY_W(VEC_W), .LATENCY(LATENCY)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_in  (in_valid),
      .pay_in  (extr),
      .vld_out (out_valid),
      .pay_out (out_llr)
   );

   // Cycles since reset, saturating at LATENCY, for the early-valid check.
   logic [CNT_W-1:0] boot_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         boot_cnt <= '0;
      else if (boot_cnt < CNT_W'(LATENCY))
         boot_cnt <= boot_cnt + 1'b1;
   end

   a_r7_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_cnt < CNT_W'(LATENCY)) |-> !out_valid)
      else $error("R7: out_valid before pipeline filled");

   a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_llr))
      else $error("R8: out_llr changed without out_valid");

endmodule

// File: tb/llr_check_node_tb_top.sv
`timescale 1ns/1ps
module llr_check_node_tb_top;
   localparam int D   = 4;
   localparam int W   = 8;
   localparam int LAT = 2;
   localparam int HI  = 127;
   localparam int LO  = -128;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [D*W-1:0] in_llr = '0;
   logic           out_valid;
   logic [D*W-1:0] out_llr;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   llr_check_node #(.DEGREE(D), .DATA_W(W), .FRAC_W(3), .LATENCY(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
      .out_valid(out_valid), .out_llr(out_llr)
   );

   typedef struct { bit v; int x[D]; int tag; } beat_t;
   beat_t pend[$];
   beat_t prev;
   bit    mdl_v = 0;
   int    mdl_o[D];

   function automatic int sat(int v);
      return (v > HI) ? HI : ((v < LO) ? LO : v);
   endfunction
   function automatic int mstar(int a, int b);
      int m = (a > b) ? a : b;
      int d = (a > b) ? a - b : b - a;
      return (d <= 16) ? m + 3 : m;
   endfunction
   function automatic int bplus(int a, int b);
      return sat(mstar(a, b) - mstar(0, sat(a + b)));
   endfunction
   function automatic int iabs(int a);
      return (a < 0) ? -a : a;
   endfunction
   function automatic int edge_out(beat_t b, int e);
      int left = 0, right = 0;
      bit hl = 0, hr = 0;
      for (int k = 0; k < e; k++) begin
         left = hl ? bplus(left, b.x[k]) : b.x[k];
         hl = 1;
      end
      for (int k = D-1; k > e; k--) begin
         right = hr ? bplus(b.x[k], right) : b.x[k];
         hr = 1;
      end
      if (!hl) return right;
      if (!hr) return left;
      return bplus(left, right);
   endfunction
   function automatic int dut_edge(int e);
      return int'($signed(out_llr[e*W +: W]));
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(bit v, int a, int b, int c, int d, int tag);
      beat_t n;
      n.v = v; n.x[0] = a; n.x[1] = b; n.x[2] = c; n.x[3] = d; n.tag = tag;
      in_valid = v;
      for (int e = 0; e < D; e++) in_llr[e*W +: W] = W'(n.x[e]);
      prev = n;
   endtask

   // Called at a falling edge: advance the model by the rising edge just passed, then compare.
   task automatic step();
      beat_t h;
      pend.push_back(prev);
      if (pend.size() >= LAT) begin
         h = pend.pop_front();
         mdl_v = h.v;
         if (h.v) begin
            for (int e = 0; e < D; e++) mdl_o[e] = edge_out(h, e);
         end
      end else begin
         mdl_v = 0;
      end
      chk(out_valid == mdl_v, "R7 valid timing", int'(out_valid), int'(mdl_v));
      for (int e = 0; e < D; e++)
         chk(dut_edge(e) == mdl_o[e], mdl_v ? "R6 edge value" : "R8 held value",
             dut_edge(e), mdl_o[e]);
      if (mdl_v && h.tag == 9)
         chk(dut_edge(0) == 3, "R9 worked example", dut_edge(0), 3);
      if (mdl_v && h.tag == 4)
         for (int e = 1; e < D; e++)
            chk(dut_edge(e) == 0, "R4 zero edge", dut_edge(e), 0);
      if (mdl_v && h.tag == 10)
         for (int e = 0; e < D; e++)
            chk(dut_edge(e) == mdl_o[e], "R10 saturation", dut_edge(e), mdl_o[e]);
      if (mdl_v && h.tag == 2)
         for (int e = 0; e < D; e++)
            chk(dut_edge(e) == mdl_o[e], "R2 window edge", dut_edge(e), mdl_o[e]);
      if (mdl_v) begin
         for (int e = 0; e < D; e++) begin
            int mn = 1 << 30;
            for (int k = 0; k < D; k++)
               if (k != e && iabs(h.x[k]) < mn) mn = iabs(h.x[k]);
            chk(iabs(dut_edge(e)) <= mn + 3*(D-2), "R5 magnitude bound",
                iabs(dut_edge(e)), mn + 3*(D-2));
         end
      end
   endtask

   task automatic beat(bit v, int a, int b, int c, int d, int tag);
      @(negedge clk);
      step();
      drive(v, a, b, c, d, tag);
   endtask

   function automatic int rnd_llr(int span);
      return int'($urandom_range(2*span, 0)) - span;
   endfunction

   initial begin
      for (int e = 0; e < D; e++) mdl_o[e] = 0;
      prev.v = 0; prev.tag = 0;
      for (int e = 0; e < D; e++) prev.x[e] = 0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
      chk(out_llr == '0, "R7 reset data", int'(out_llr), 0);
      rst_n = 1'b1;
      drive(0, 0, 0, 0, 0, 0);
      // R9 worked example and R1 packing
      beat(1, -57, -12, -3, 46, 9);
      // R4 zero on edge 0
      beat(1, 0, 20, -33, 7, 4);
      // R2 window boundary: difference 16 then 17
      beat(1, 40, 24, -60, 10, 2);
      beat(1, 40, 23, -60, 10, 2);
      beat(1, -8, 8, 5, -11, 2);
      beat(1, -8, 9, 5, -12, 2);
      // R8 bubble with garbage data
      beat(0, 99, -99, 55, -55, 0);
      beat(0, 1, 2, 3, 4, 0);
      // R3 and R10 extremes
      beat(1, HI, HI, HI, HI, 10);
      beat(1, LO, LO, LO, LO, 10);
      beat(1, HI, LO, HI, LO, 10);
      beat(1, LO, HI, 0, HI, 10);
      beat(0, -7, 7, -7, 7, 0);
      // R6 mixed traffic with random bubbles
      for (int i = 0; i < 400; i++) begin
         int span = (i % 3 == 0) ? 20 : ((i % 3 == 1) ? 60 : 128);
         bit v = ($urandom_range(3, 0) != 0);
         beat(v, sat(rnd_llr(span)), sat(rnd_llr(span)), sat(rnd_llr(span)),
              sat(rnd_llr(span)), 6);
      end
      for (int i = 0; i < LAT + 2; i++) beat(0, 0, 0, 0, 0, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule